// File: doc/BRIEF.md
# Video Input Mode Detector

This block sits on the input side of a display controller. It receives a raster video stream: a pixel clock, horizontal and vertical sync, an optional data-enable, 4-bit pixels, a resolution select pin and two luminance select pins. It decides which of six operating modes applies. It then produces a capture strobe that marks the input pixels falling inside a 320x240 window. The pixels are passed along one clock later, so the frame store downstream can write them directly.

The mode is not taken from a static pin alone. Data-enable activity is counted over a periodic evaluation window of about 25 ms, and the result decides between the modes. The first mode family places pixels by where data-enable is high. The second places them at a fixed offset from horizontal sync. The third starts them on the first clock after sync. With the resolution select high, the same window picks out only the upper-left quarter of a 640x480 raster. A newly chosen mode is held back until the next vertical sync leading edge, so no captured frame mixes two modes. The exception is self-test, which ignores the video and applies at once.

Top module: `vid_mode_detect`

## Requirements
- R1: When both luminance selects are 1 at the end of an evaluation window, mode_o becomes 5 (self-test) on the next clock, without waiting for vertical sync, and cap_o stays 0 for as long as that mode holds, whatever the video inputs do.
- R2: If data-enable stays 1 with no transition for a whole evaluation window, the mode becomes 4, whatever the resolution select is. In mode 4 the line's pixel 0 is the one sampled on the first rising edge after the edge where horizontal sync is first seen high, and pixels 0 to 319 are captured.
- R3: Data-enable counts as active only when more than 8 level changes are sampled in one evaluation window. A window with 8 or fewer changes, and not held high, selects a fixed-offset mode.
- R4: The choice is re-made once every WIN_CLKS pixel clocks (default 160000, which is 25 ms at 6.4 MHz). The mode can move between any two modes at successive evaluations without a reset.
- R5: With resolution select 0, active data-enable gives mode 0. In mode 0 the first 320 data-enable-high pixels of a line are captured, in the first 240 lines since vertical sync that carry data-enable.
- R6: With resolution select 0 and inactive data-enable, the mode is 1. With resolution select 1, active data-enable gives mode 2 (captured as in mode 0) and inactive data-enable gives mode 3 (captured as in mode 1). Modes 2 and 3 thus take the upper-left 320x240 of a 640x480 input. No line ever carries more than 320 strobes.
- R7: Modes 1 and 3 capture line pixels HOFF to HOFF+319 (default HOFF 40), with pixels numbered as in R2. In modes 1, 3 and 4 the captured lines are VOFF to VOFF+239. The line in which the vertical sync leading edge is seen is line 0, and each later horizontal sync leading edge starts the next line.
- R8: Any change of mode_o to a mode other than 5 appears only on the clock after the edge where the vertical sync leading edge is sampled.
- R9: pix_o presents, one clock later, the pixel sampled on the same edge as the decision shown on cap_o.
- R10: After reset, mode_o is 1 and cap_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high; leading edge starts a line |
| vsync | input | 1 | Vertical sync, active high; leading edge starts a frame |
| den | input | 1 | Data-enable, may toggle, be held high or held low |
| res_sel | input | 1 | 0: 320x240 source, 1: 640x480 source (quadrant crop) |
| lum_a | input | 1 | Luminance select, first bit |
| lum_b | input | 1 | Luminance select, second bit |
| pix_in | input | PW | Input pixel, 4 bits by default |
| mode_o | output | 3 | Mode in force, codes 0 to 5 as in the requirements |
| cap_o | output | 1 | High when pix_o belongs to the 320x240 window |
| pix_o | output | PW | Pixel delayed by one clock, aligned with cap_o |

## Verification
The assertions assume the sync pulses are wider than one clock. They also assume that a data-enable pulse never begins on the same clock as a horizontal sync leading edge, and that lines run longer than the capture window, so that a stale position count cannot fall inside the window. The stimulus builds every line from a fixed template: sync in the first two clocks, data-enable well away from it, and lines several clocks longer than the window. Before any frame is scored, it holds each input pattern for more than two evaluation windows plus one frame. The sparse data-enable pattern is spaced so that no window can see more than exactly eight changes.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

    typedef enum logic [2:0] {
        MD_QVGA_DE  = 3'd0,
        MD_QVGA_FIX = 3'd1,
        MD_VGA_DE   = 3'd2,
        MD_VGA_FIX  = 3'd3,
        MD_HS_START = 3'd4,
        MD_SELFTEST = 3'd5
    } vmd_mode_e;

    function automatic logic mode_is_de(vmd_mode_e m);
        return (m == MD_QVGA_DE) || (m == MD_VGA_DE);
    endfunction

    function automatic logic mode_is_fix(vmd_mode_e m);
        return (m == MD_QVGA_FIX) || (m == MD_VGA_FIX);
    endfunction

endpackage

// File: rtl/vmd_activity.sv
module vmd_activity
    import vmd_pkg::*;
#(
    parameter int WIN_CLKS = 160000,
    parameter int TGL_MIN  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      den,
    input  logic      res_sel,
    input  logic      lum_a,
    input  logic      lum_b,
    output vmd_mode_e pend_mode,
    output logic      pend_stb
);

    localparam int WW = (WIN_CLKS > 2) ? $clog2(WIN_CLKS) : 1;
    localparam int TW = $clog2(TGL_MIN + 2);
    localparam logic [WW-1:0] WLAST = WW'(WIN_CLKS - 1);
    localparam logic [TW-1:0] TSAT  = TW'(TGL_MIN + 1);
    localparam logic [TW-1:0] TLIM  = TW'(TGL_MIN);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [TW-1:0] tcnt;
        logic          den;
        vmd_mode_e     pend;
        logic          stb;
    } act_s;

    act_s s_d, s_q;

    always_comb begin
        logic [TW-1:0] tsum;
        vmd_mode_e     pick;

        s_d     = s_q;
        s_d.den = den;
        s_d.stb = 1'b0;

        // transitions seen so far, including this sample
        tsum = s_q.tcnt;
        if ((den ^ s_q.den) && (s_q.tcnt != TSAT)) begin
            tsum = s_q.tcnt + 1'b1;
        end

        if (lum_a && lum_b) begin
            pick = MD_SELFTEST;
        end else if (tsum > TLIM) begin
            pick = res_sel ? MD_VGA_DE : MD_QVGA_DE;
        end else if ((tsum == '0) && den) begin
            pick = MD_HS_START;
        end else begin
            pick = res_sel ? MD_VGA_FIX : MD_QVGA_FIX;
        end

        if (s_q.win == WLAST) begin
            s_d.win  = '0;
            s_d.tcnt = '0;
            s_d.pend = pick;
            s_d.stb  = 1'b1;
        end else begin
            s_d.win  = s_q.win + 1'b1;
            s_d.tcnt = tsum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{win: '0, tcnt: '0, den: 1'b0, pend: MD_QVGA_FIX, stb: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_mode = s_q.pend;
    assign pend_stb  = s_q.stb;

    AST_TGL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tcnt <= TSAT);                                               // R3

    AST_EVAL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_stb |=> !pend_stb);                                         // R4

    AST_SELFTEST_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_stb && $past(lum_a && lum_b)) |-> (pend_mode == MD_SELFTEST)); // R1

endmodule

// File: rtl/vmd_window.sv
module vmd_window
    import vmd_pkg::*;
#(
    parameter int H_ACT = 320,
    parameter int V_ACT = 240,
    parameter int HOFF  = 40,
    parameter int VOFF  = 2,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync,
    input  logic          vsync,
    input  logic          den,
    input  logic [PW-1:0] pix,
    input  vmd_mode_e     mode,
    output logic          cap,
    output logic [PW-1:0] pix_out,
    output logic          vs_rise
);

    localparam int CW  = $clog2(HOFF + H_ACT + VOFF + V_ACT + 4) + 1;
    localparam int HDW = $clog2(H_ACT + 1);
    localparam int VDW = $clog2(V_ACT + 1);
    localparam logic [CW-1:0]  CMAX  = '1;
    localparam logic [CW-1:0]  H_END = CW'(H_ACT);
    localparam logic [CW-1:0]  F_BEG = CW'(HOFF);
    localparam logic [CW-1:0]  F_END = CW'(HOFF + H_ACT);
    localparam logic [CW-1:0]  V_BEG = CW'(VOFF);
    localparam logic [CW-1:0]  V_END = CW'(VOFF + V_ACT);
    localparam logic [HDW-1:0] DE_H  = HDW'(H_ACT);
    localparam logic [VDW-1:0] DE_V  = VDW'(V_ACT);

    typedef struct packed {
        logic           hs;
        logic           vs;
        logic [CW-1:0]  hpos;
        logic [CW-1:0]  vpos;
        logic [HDW-1:0] decnt;
        logic [VDW-1:0] deline;
        logic           linede;
        logic           cap;
        logic [PW-1:0]  pix;
    } win_s;

    win_s w_d, w_q;
    logic hs_r, vs_r;

    assign hs_r = hsync & ~w_q.hs;
    assign vs_r = vsync & ~w_q.vs;

    always_comb begin
        logic vwin, hwin_s, hwin_f, de_cap;

        w_d     = w_q;
        w_d.hs  = hsync;
        w_d.vs  = vsync;
        w_d.pix = pix;

        // pixel position inside the line
        if (hs_r) begin
            w_d.hpos = '0;
        end else if (w_q.hpos != CMAX) begin
            w_d.hpos = w_q.hpos + 1'b1;
        end

        // line position inside the frame
        if (vs_r) begin
            w_d.vpos = '0;
        end else if (hs_r && (w_q.vpos != CMAX)) begin
            w_d.vpos = w_q.vpos + 1'b1;
        end

        // data-enable referenced counters
        if (hs_r) begin
            w_d.decnt = '0;
        end else if (den && (w_q.decnt < DE_H)) begin
            w_d.decnt = w_q.decnt + 1'b1;
        end

        if (vs_r || hs_r) begin
            w_d.linede = 1'b0;
        end else begin
            w_d.linede = w_q.linede | den;
        end

        if (vs_r) begin
            w_d.deline = '0;
        end else if (hs_r && w_q.linede && (w_q.deline < DE_V)) begin
            w_d.deline = w_q.deline + 1'b1;
        end

        vwin   = (w_q.vpos >= V_BEG) && (w_q.vpos < V_END);
        hwin_s = (w_q.hpos < H_END);
        hwin_f = (w_q.hpos >= F_BEG) && (w_q.hpos < F_END);
        de_cap = den && (w_q.decnt < DE_H) && (w_q.deline < DE_V);

        case (mode)
            MD_HS_START:              w_d.cap = !hs_r && hwin_s && vwin;
            MD_QVGA_FIX, MD_VGA_FIX:  w_d.cap = !hs_r && hwin_f && vwin;
            MD_QVGA_DE, MD_VGA_DE:    w_d.cap = !hs_r && de_cap;
            default:                  w_d.cap = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{hs: 1'b0, vs: 1'b0, hpos: '1, vpos: '1, decnt: '0,
                     deline: '1, linede: 1'b0, cap: 1'b0, pix: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign cap     = w_q.cap;
    assign pix_out = w_q.pix;
    assign vs_rise = vs_r;

    // checker: strobes per line
    logic [HDW:0] linecap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            linecap_q <= '0;
        end else if (hs_r) begin
            linecap_q <= '0;
        end else if (w_q.cap && (linecap_q != '1)) begin
            linecap_q <= linecap_q + 1'b1;
        end
    end

    AST_LINE_CAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        linecap_q <= (HDW+1)'(H_ACT));                                   // R6

    AST_DE_CAP_NEEDS_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && $past(mode_is_de(mode))) |-> $past(den));                // R5

    AST_FIX_CAP_AFTER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && $past(mode_is_fix(mode))) |-> !$past(hs_r));             // R7

endmodule

// File: rtl/vid_mode_detect.sv
module vid_mode_detect
    import vmd_pkg::*;
#(
    parameter int H_ACT    = 320,
    parameter int V_ACT    = 240,
    parameter int HOFF     = 40,
    parameter int VOFF     = 2,
    parameter int PW       = 4,
    parameter int WIN_CLKS = 160000,
    parameter int TGL_MIN  = 8
) (
    input  logic          clk_pix,
    input  logic          rst_n,
    input  logic          hsync,
    input  logic          vsync,
    input  logic          den,
    input  logic          res_sel,
    input  logic          lum_a,
    input  logic          lum_b,
    input  logic [PW-1:0] pix_in,
    output logic [2:0]    mode_o,
    output logic          cap_o,
    output logic [PW-1:0] pix_o
);

    typedef struct packed {
        vmd_mode_e mode;
    } top_s;

    top_s      t_d, t_q;
    vmd_mode_e pend_mode;
    logic      pend_stb;
    logic      vs_rise;

    vmd_activity #(
        .WIN_CLKS (WIN_CLKS),
        .TGL_MIN  (TGL_MIN)
    ) u_activity (
        .clk       (clk_pix),
        .rst_n     (rst_n),
        .den       (den),
        .res_sel   (res_sel),
        .lum_a     (lum_a),
        .lum_b     (lum_b),
        .pend_mode (pend_mode),
        .pend_stb  (pend_stb)
    );

    vmd_window #(
        .H_ACT (H_ACT),
        .V_ACT (V_ACT),
        .HOFF  (HOFF),
        .VOFF  (VOFF),
        .PW    (PW)
    ) u_window (
        .clk     (clk_pix),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .vsync   (vsync),
        .den     (den),
        .pix     (pix_in),
        .mode    (t_q.mode),
        .cap     (cap_o),
        .pix_out (pix_o),
        .vs_rise (vs_rise)
    );

    always_comb begin
        t_d = t_q;
        if (pend_stb && (pend_mode == MD_SELFTEST)) begin
            t_d.mode = MD_SELFTEST;
        end else if (vs_rise) begin
            t_d.mode = pend_mode;
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{mode: MD_QVGA_FIX};
        end else begin
            t_q <= t_d;
        end
    end

    assign mode_o = t_q.mode;

    AST_MODE_AT_FRAME_EDGE: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (t_q.mode != $past(t_q.mode)) |-> ($past(vs_rise) || (t_q.mode == MD_SELFTEST))); // R8

    AST_SELFTEST_SILENT: assert property (@(posedge clk_pix) disable iff (!rst_n)
        ((t_q.mode == MD_SELFTEST) && ($past(t_q.mode) == MD_SELFTEST)) |-> !cap_o);  // R1

    AST_MODE_LEGAL: assert property (@(posedge clk_pix) disable iff (!rst_n)
        mode_o <= 3'd5);                                                 // R4

endmodule

// File: tb/test_vid_mode_detect.sv
module test_vid_mode_detect;

    localparam int H   = 8;
    localparam int V   = 4;
    localparam int HO  = 5;
    localparam int VO  = 2;
    localparam int WIN = 300;
    localparam int LL  = 24;
    localparam int FL  = 8;

    // video styles and expected capture kinds
    localparam int DS_LOW = 0, DS_DE = 1, DS_HELD = 2, DS_SPARSE = 3;
    localparam int EK_FIX = 0, EK_DE = 1, EK_HS = 2, EK_NONE = 3;

    logic       clk = 1'b0;
    logic       rst_n, hsync, vsync, den, res_sel, lum_a, lum_b;
    logic [3:0] pix_in, pix_o;
    logic [2:0] mode_o;
    logic       cap_o;

    always #10 clk = ~clk;

    vid_mode_detect #(
        .H_ACT(H), .V_ACT(V), .HOFF(HO), .VOFF(VO), .PW(4),
        .WIN_CLKS(WIN), .TGL_MIN(8)
    ) i_vid_mode_detect (
        .clk_pix(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .den(den), .res_sel(res_sel), .lum_a(lum_a), .lum_b(lum_b),
        .pix_in(pix_in), .mode_o(mode_o), .cap_o(cap_o), .pix_o(pix_o)
    );

    int         n_chk = 0;
    int         n_err = 0;
    int         gcyc  = 0;
    int         n_pop = 0;
    bit         rec   = 1'b0;
    bit         live  = 1'b0;
    bit         done  = 1'b0;
    logic [3:0] expq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    // driver: one frame of FL lines, LL clocks each
    task automatic drive_frame(input int ds, input int ek, input bit r);
        for (int ln = 0; ln < FL; ln++) begin
            for (int c = 0; c < LL; c++) begin
                logic [3:0] p;
                bit         e;
                bit         dv;
                @(negedge clk);
                gcyc++;
                hsync = (c < 2);
                vsync = (ln == 0) && (c < 4);
                case (ds)
                    DS_DE:     dv = (ln >= 1) && (ln <= 6) && (c >= 10) && (c <= 19);
                    DS_HELD:   dv = 1'b1;
                    DS_SPARSE: dv = ((gcyc % 80) < 2);
                    default:   dv = 1'b0;
                endcase
                den    = dv;
                p      = 4'(ln * 5 + c * 3);
                pix_in = p;
                case (ek)
                    EK_FIX:  e = (c >= 1 + HO) && (c <= HO + H) && (ln >= VO) && (ln < VO + V);
                    EK_HS:   e = (c >= 1) && (c <= H) && (ln >= VO) && (ln < VO + V);
                    EK_DE:   e = dv && (c - 10 < H) && (ln - 1 < V);
                    default: e = 1'b0;
                endcase
                if (r && e) expq.push_back(p);
            end
        end
    endtask

    // monitor: scoreboard pop on each strobe (R9 data, R5/R6/R7 placement)
    always @(negedge clk) begin
        if (rec && cap_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", 1, 0);
            end else begin
                logic [3:0] x;
                x = expq.pop_front();
                n_pop++;
                check(pix_o == x, "R9 pixel", int'(pix_o), int'(x));
            end
        end
    end

    // R8 monitor: mode moves only after a sampled vsync leading edge (or to 5)
    logic       vs_last = 1'b0;
    logic       vs_seen = 1'b0;
    logic [2:0] mprev   = 3'd1;
    always @(posedge clk) begin
        vs_seen = vsync && !vs_last;
        vs_last = vsync;
    end
    always @(negedge clk) begin
        if (live && (mode_o != mprev)) begin
            check((mode_o == 3'd5) || vs_seen, "R8 mode change off frame edge",
                  int'(mode_o), int'(mprev));
        end
        mprev = mode_o;
    end

    // one configuration: settle, check mode, score one frame
    task automatic run_cfg(input int ds, input bit rs, input bit la, input bit lb,
                           input int ek, input int exp_mode, input string req);
        res_sel = rs;
        lum_a   = la;
        lum_b   = lb;
        for (int f = 0; f < 5; f++) drive_frame(ds, ek, 1'b0);
        check(mode_o == 3'(exp_mode), req, int'(mode_o), exp_mode);
        expq.delete();
        n_pop = 0;
        rec   = 1'b1;
        drive_frame(ds, ek, 1'b1);
        @(negedge clk);
        rec = 1'b0;
        #1;
        check(expq.size() == 0, {req, " strobes missing"}, expq.size(), 0);
        check(n_pop == ((ek == EK_NONE) ? 0 : H * V), {req, " strobe count"},
              n_pop, (ek == EK_NONE) ? 0 : H * V);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; den = 1'b0;
        res_sel = 1'b0; lum_a = 1'b0; lum_b = 1'b0; pix_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(mode_o == 3'd1, "R10 mode after reset", int'(mode_o), 1);
        check(cap_o == 1'b0, "R10 strobe after reset", int'(cap_o), 0);
        live = 1'b1;

        // R4: successive configurations change mode without reset
        run_cfg(DS_LOW,    1'b0, 1'b0, 1'b0, EK_FIX,  1, "R6 fixed 320x240 mode");
        run_cfg(DS_DE,     1'b0, 1'b0, 1'b0, EK_DE,   0, "R5 DE 320x240 mode");
        run_cfg(DS_DE,     1'b1, 1'b0, 1'b0, EK_DE,   2, "R6 DE 640x480 crop");
        run_cfg(DS_LOW,    1'b1, 1'b0, 1'b0, EK_FIX,  3, "R6 fixed 640x480 crop");
        run_cfg(DS_HELD,   1'b1, 1'b0, 1'b0, EK_HS,   4, "R2 DE held high");
        run_cfg(DS_DE,     1'b0, 1'b1, 1'b1, EK_NONE, 5, "R1 self-test");
        run_cfg(DS_SPARSE, 1'b0, 1'b0, 1'b0, EK_FIX,  1, "R3 eight changes inactive");
        run_cfg(DS_DE,     1'b0, 1'b1, 1'b0, EK_DE,   0, "R1 one select only");
        run_cfg(DS_HELD,   1'b0, 1'b0, 1'b0, EK_HS,   4, "R2 held high, select 0");
        run_cfg(DS_LOW,    1'b0, 1'b0, 1'b0, EK_FIX,  1, "R4 back to fixed");

        finish_run();
    end

endmodule